// File: doc/BRIEF.md
# Register-format integer execute unit

This block executes the register-to-register group of a classic 32-bit integer instruction set in a single cycle. Each cycle with `issue` high it takes the instruction word and the two source operands already read from the register file. It then presents a destination write, as a write enable, an index and data, combinationally in the same cycle. The register file is expected to capture that write on the next rising clock edge.

The unit owns the two side registers HI and LO that hold a 64-bit product. They change only at the clock edge that ends a multiply or a move-to instruction.

Operations that the unit does not perform raise a flag instead of producing a write. The trapping add and subtract raise an arithmetic-trap flag. The system-call and breakpoint codes raise their own pulses. Every other unassigned function code raises a reserved-instruction flag.

Top module: `int_exec_rformat`

## Requirements
- R1: The function code sits in bits 5:0, s in bits 25:21, t in bits 20:16, d in bits 15:11 and the fixed shift amount in bits 10:6. Code 0 writes t shifted left by the fixed amount. Code 4 writes t shifted left by the low 5 bits of the s operand.
- R2: Code 3 writes t shifted right by the fixed amount, filling with copies of bit 31 of t.
- R3: Code 33 writes s+t and code 35 writes s-t, both modulo 2^32, with no flag raised.
- R4: Codes 36, 37, 38 and 39 write s AND t, s OR t, s XOR t and NOT(s OR t), in that order.
- R5: Code 24 forms the signed 64-bit product of s and t. At the next clock edge it loads the upper half into HI and the lower half into LO, and it makes no destination write.
- R6: Code 25 does the same as R5 but treats both operands as unsigned.
- R7: Code 16 writes HI and code 18 writes LO to d. At the next clock edge, code 17 loads s into HI and code 19 loads s into LO.
- R8: `wr_en` is never high with d equal to 0. Such a write is dropped, while any HI/LO effect of the instruction still occurs.
- R9: Codes 32 and 34 raise `arith_trap` for the cycle and make no destination or HI/LO write.
- R10: Every code not named in R1-R7, R9 or R11 raises `rsvd_instr` for the cycle and makes no destination or HI/LO write.
- R11: Code 12 raises `syscall_pulse` and code 13 raises `break_pulse` for the cycle, with no destination or HI/LO write.
- R12: After reset HI and LO read 0. They change only as given in R5-R7. With `issue` low, no output flag or write enable is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of HI/LO |
| issue | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| src_s | input | 32 | Operand read from register s |
| src_t | input | 32 | Operand read from register t |
| wr_en | output | 1 | Destination write request |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 32 | Destination write data |
| hi_q | output | 32 | Current HI register |
| lo_q | output | 32 | Current LO register |
| arith_trap | output | 1 | Trapping add/subtract seen |
| rsvd_instr | output | 1 | Unassigned function code seen |
| syscall_pulse | output | 1 | System-call code seen |
| break_pulse | output | 1 | Breakpoint code seen |

## Verification
The bench targets several operand cases. Arithmetic right shifts of negative words would come out zero-filled if the shift were logical. Signed multiplies of mixed-sign and most-negative operands would give a wrong HI if the operands were zero-extended. Variable shift amounts with high s bits set would shift by too much if all of s were used.

It also issues every assigned code with d equal to 0, which must drop the write. A dropped mult or move-to must still update HI/LO; a design that gated that on d would not.

Finally, it sweeps all 64 function codes with `issue` both high and low. A trapping add that silently wrapped, a reserved code that wrote a result, and a HI/LO register that moved on a non-multiply would each show as a mismatch against the model.

// File: rtl/int_exec_rformat.sv
module int_exec_rformat #(
  parameter int W = 32,
  parameter logic [W-1:0] HILO_RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic [31:0]  instr,
  input  logic [W-1:0] src_s,
  input  logic [W-1:0] src_t,
  output logic         wr_en,
  output logic [4:0]   wr_idx,
  output logic [W-1:0] wr_data,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q,
  output logic         arith_trap,
  output logic         rsvd_instr,
  output logic         syscall_pulse,
  output logic         break_pulse
);
  localparam int SHW = $clog2(W);

  logic [5:0]     fn;
  logic [4:0]     sa;
  logic [2*W-1:0] prod_s, prod_u;
  logic           want_wr, hi_we, lo_we, f_trap, f_rsvd, f_sys, f_brk;
  logic [W-1:0]   res, hi_nx, lo_nx;

  assign fn     = instr[5:0];
  assign sa     = instr[10:6];
  assign wr_idx = instr[15:11];

  assign prod_s = {{W{src_s[W-1]}}, src_s} * {{W{src_t[W-1]}}, src_t};
  assign prod_u = {{W{1'b0}}, src_s} * {{W{1'b0}}, src_t};

  always_comb begin
    res = '0; want_wr = 1'b0;
    hi_we = 1'b0; lo_we = 1'b0; hi_nx = src_s; lo_nx = src_s;
    f_trap = 1'b0; f_rsvd = 1'b0; f_sys = 1'b0; f_brk = 1'b0;
    case (fn)
      6'd0:  begin res = src_t << sa; want_wr = 1'b1; end
      6'd3:  begin res = W'($signed(src_t) >>> sa); want_wr = 1'b1; end
      6'd4:  begin res = src_t << src_s[SHW-1:0]; want_wr = 1'b1; end
      6'd12: f_sys = 1'b1;
      6'd13: f_brk = 1'b1;
      6'd16: begin res = hi_q; want_wr = 1'b1; end
      6'd17: hi_we = 1'b1;
      6'd18: begin res = lo_q; want_wr = 1'b1; end
      6'd19: lo_we = 1'b1;
      6'd24: begin hi_we = 1'b1; lo_we = 1'b1;
                   hi_nx = prod_s[2*W-1:W]; lo_nx = prod_s[W-1:0]; end
      6'd25: begin hi_we = 1'b1; lo_we = 1'b1;
                   hi_nx = prod_u[2*W-1:W]; lo_nx = prod_u[W-1:0]; end
      6'd32, 6'd34: f_trap = 1'b1;
      6'd33: begin res = src_s + src_t; want_wr = 1'b1; end
      6'd35: begin res = src_s - src_t; want_wr = 1'b1; end
      6'd36: begin res = src_s & src_t; want_wr = 1'b1; end
      6'd37: begin res = src_s | src_t; want_wr = 1'b1; end
      6'd38: begin res = src_s ^ src_t; want_wr = 1'b1; end
      6'd39: begin res = ~(src_s | src_t); want_wr = 1'b1; end
      default: f_rsvd = 1'b1;
    endcase
  end

  assign wr_data       = res;
  assign wr_en         = issue && want_wr && (wr_idx != 5'd0);
  assign arith_trap    = issue && f_trap;
  assign rsvd_instr    = issue && f_rsvd;
  assign syscall_pulse = issue && f_sys;
  assign break_pulse   = issue && f_brk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= HILO_RST;
      lo_q <= HILO_RST;
    end else if (issue) begin
      if (hi_we) hi_q <= hi_nx;
      if (lo_we) lo_q <= lo_nx;
    end
  end

  // R8
  zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (instr[15:11] != 5'd0));

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, arith_trap, rsvd_instr, syscall_pulse, break_pulse}));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |-> !(wr_en || arith_trap || rsvd_instr || syscall_pulse || break_pulse));

  // R10
  rsvd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsvd_instr || arith_trap) |=> ($stable(hi_q) && $stable(lo_q)));

  // R7
  mthi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && instr[5:0] == 6'd17) |=> (hi_q == $past(src_s) && $stable(lo_q)));
endmodule

// File: tb/int_exec_rformat_test.sv
`timescale 1ns/1ps
module int_exec_rformat_test;
  logic clk = 1'b0, rst_n = 1'b0, issue = 1'b0;
  logic [31:0] instr = '0, src_s = '0, src_t = '0;
  logic wr_en, arith_trap, rsvd_instr, syscall_pulse, break_pulse;
  logic [4:0] wr_idx;
  logic [31:0] wr_data, hi_q, lo_q;
  int checks = 0, fails = 0;
  logic [31:0] m_hi = '0, m_lo = '0;

  always #2.5 clk = ~clk;

  int_exec_rformat uut (.clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
    .src_s(src_s), .src_t(src_t), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .hi_q(hi_q), .lo_q(lo_q), .arith_trap(arith_trap), .rsvd_instr(rsvd_instr),
    .syscall_pulse(syscall_pulse), .break_pulse(break_pulse));

  function automatic string req_of(input logic [5:0] f);
    case (f)
      0, 4: return "R1";   3: return "R2";   33, 35: return "R3";
      36, 37, 38, 39: return "R4";   24: return "R5";   25: return "R6";
      16, 17, 18, 19: return "R7";   32, 34: return "R9";
      12, 13: return "R11";   default: return "R10";
    endcase
  endfunction

  task automatic cmp(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // drive one cycle, compare all outputs against the model, advance the model
  task automatic step(input logic iv, input logic [5:0] f, input logic [4:0] d,
                      input logic [4:0] sh, input logic [31:0] s, input logic [31:0] t);
    logic [31:0] e_data; logic e_we, e_tr, e_rs, e_sy, e_bk, want;
    logic [31:0] n_hi, n_lo; longint ps; longint unsigned pu; string rq;
    @(negedge clk);
    issue = iv; instr = {6'd0, 5'd7, 5'd9, d, sh, f}; src_s = s; src_t = t;
    #1;
    rq = iv ? req_of(f) : "R12";
    if (d == 0 && iv) rq = {rq, "/R8"};
    e_data = '0; want = 0; e_tr = 0; e_rs = 0; e_sy = 0; e_bk = 0;
    n_hi = m_hi; n_lo = m_lo;
    ps = longint'($signed(s)) * longint'($signed(t));
    pu = longint'({32'd0, s}) * longint'({32'd0, t});
    case (f)
      0: begin want = 1; e_data = t << sh; end
      3: begin want = 1; e_data = t; for (int k = 0; k < sh; k++) e_data = {e_data[31], e_data[31:1]}; end
      4: begin want = 1; e_data = t << s[4:0]; end
      12: e_sy = 1;  13: e_bk = 1;
      16: begin want = 1; e_data = m_hi; end
      17: n_hi = s;
      18: begin want = 1; e_data = m_lo; end
      19: n_lo = s;
      24: begin n_hi = ps[63:32]; n_lo = ps[31:0]; end
      25: begin n_hi = pu[63:32]; n_lo = pu[31:0]; end
      32, 34: e_tr = 1;
      33: begin want = 1; e_data = s + t; end
      35: begin want = 1; e_data = s - t; end
      36: begin want = 1; e_data = s & t; end
      37: begin want = 1; e_data = s | t; end
      38: begin want = 1; e_data = s ^ t; end
      39: begin want = 1; e_data = ~(s | t); end
      default: e_rs = 1;
    endcase
    e_we = iv && want && d != 0;
    cmp(rq, "wr_en", {31'd0, wr_en}, {31'd0, e_we});
    if (e_we) begin
      cmp(rq, "wr_idx", {27'd0, wr_idx}, {27'd0, d});
      cmp(rq, "wr_data", wr_data, e_data);
    end
    cmp(rq, "flags", {28'd0, arith_trap, rsvd_instr, syscall_pulse, break_pulse},
        {28'd0, iv && e_tr, iv && e_rs, iv && e_sy, iv && e_bk});
    cmp(rq, "hi_q", hi_q, m_hi);
    cmp(rq, "lo_q", lo_q, m_lo);
    if (iv) begin m_hi = n_hi; m_lo = n_lo; end
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12 reset state
    cmp("R12", "hi reset", hi_q, 32'd0);
    cmp("R12", "lo reset", lo_q, 32'd0);
    step(1, 0, 3, 4, 32'h0, 32'h8000_00F1);            // R1
    step(1, 0, 3, 31, 32'h0, 32'h0000_0003);
    step(1, 4, 5, 0, 32'hFFFF_FFE3, 32'h0000_0001);    // R1 only low 5 bits of s
    step(1, 3, 6, 4, 32'h0, 32'h8000_0010);            // R2 negative
    step(1, 3, 6, 31, 32'h0, 32'h8000_0000);
    step(1, 3, 6, 8, 32'h0, 32'h7F00_0000);            // R2 positive
    step(1, 33, 8, 0, 32'hFFFF_FFFF, 32'h0000_0002);   // R3 wrap
    step(1, 35, 8, 0, 32'h0000_0000, 32'h0000_0001);
    step(1, 36, 1, 0, 32'hF0F0_1234, 32'h0FF0_FF00);   // R4
    step(1, 37, 1, 0, 32'hF0F0_1234, 32'h0FF0_FF00);
    step(1, 38, 1, 0, 32'hF0F0_1234, 32'h0FF0_FF00);
    step(1, 39, 1, 0, 32'hF0F0_1234, 32'h0FF0_FF00);
    step(1, 24, 0, 0, 32'hFFFF_FFFD, 32'h0000_0007);   // R5 mixed sign
    step(1, 16, 2, 0, 0, 0);
    step(1, 18, 2, 0, 0, 0);
    step(1, 24, 4, 0, 32'h8000_0000, 32'h8000_0000);   // R5 most negative
    step(1, 25, 4, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);   // R6
    step(1, 17, 0, 0, 32'h1357_9BDF, 0);               // R7 / R8 d=0
    step(1, 19, 0, 0, 32'h2468_ACE0, 0);
    step(1, 16, 0, 0, 0, 0);                           // R8 dropped read
    step(1, 32, 3, 0, 32'h7FFF_FFFF, 1);               // R9
    step(1, 34, 3, 0, 32'h8000_0000, 1);
    step(1, 12, 3, 0, 1, 2);                           // R11
    step(1, 13, 3, 0, 1, 2);
    for (int f = 0; f < 64; f++) begin                 // R10 sweep, also R12 idle
      step(1, 6'(f), 5'(f % 32), 5'(f % 32), 32'hA5A5_0000 + f, 32'h8C3E_1F07 ^ f);
      step(0, 6'(f), 5'd9, 5'd1, 32'h0BAD_0000 + f, 32'h1234_5678);
      step(1, 6'(f), 5'd0, 5'd3, 32'hC001_0000 + f, 32'hFFFF_0001);
    end
    step(1, 18, 11, 0, 0, 0);
    step(1, 16, 11, 0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule